// File: doc/BRIEF.md
# Sound Coprocessor Control and Port Register File

This block is the sixteen-byte register window that a sound coprocessor's CPU sees near the top of its address space. It sits on the CPU bus next to the main RAM. Every CPU write is passed through to the RAM at the same address. Reads are served from one of three places: the register window, a boot ROM image that can be mapped over the highest addresses, or the RAM.

Inside the window there are four two-way mailbox ports to a host processor. Each port has an outgoing byte that the CPU writes and a separate incoming byte that the host writes. A control register can clear the incoming bytes in pairs and can switch the boot ROM mapping on or off. The window also holds an address latch and a data port. Together they reach a 128-entry sound DSP register file indirectly. There are two scratch bytes and a test register that has no effect.

The ROM image, the port count and the bus widths are parameters.

Top module: `snd_regwin`

## Requirements
- R1: Writes from the CPU at any address appear on `ram_we`/`ram_addr`/`ram_wdata` in the same cycle. A read that hits neither the window (0xF0–0xFF) nor the mapped ROM returns `ram_rdata`. All read data appears on `cpu_rdata` one cycle after `cpu_rd` and is held until the next read.
- R2: A CPU write to window offset 4+k loads outgoing byte k, which is `port_out[8k+7:8k]`. A CPU read of offset 4+k returns incoming byte k.
- R3: A host write (`host_we` with `host_sel`=k) loads incoming byte k. The new value is visible on `port_in[8k+7:8k]` after the clock edge.
- R4: In a control write (offset 1), bit 4 clears incoming bytes 0 and 1 and bit 5 clears incoming bytes 2 and 3. If a host write lands on a cleared byte in the same cycle, the clear wins.
- R5: Control bit 7 maps the ROM over the top `ROM_BYTES` addresses. While it is set, a read there returns byte i of `ROM_IMAGE` (bits 8i+7:8i). While it is clear, the read returns RAM. Writes to that range always reach RAM.
- R6: A write to offset 2 stores the full 8-bit DSP address, and a read of offset 2 returns it. `dsp_addr` carries its low 7 bits.
- R7: A read of offset 3 returns `dsp_rdata`. A write to offset 3 pulses `dsp_we` with `dsp_wdata` equal to the written byte, but only when the stored address is 0x7F or below. Otherwise the write is dropped.
- R8: Offsets 8 and 9 are read/write storage bytes.
- R9: A write to offset 0 changes no port, DSP or ROM state. Reads of offsets 0, 1 and 10–15 return 0.
- R10: After reset the ROM mapping is on, and all port bytes, the DSP address and the scratch bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_wdata | input | DW | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rdata | output | DW | Read data, valid the cycle after `cpu_rd` |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, one cycle after address |
| host_we | input | 1 | Host write strobe |
| host_sel | input | PSEL_W | Host port index |
| host_wdata | input | DW | Host write data |
| port_out | output | NUM_PORTS*DW | Outgoing bytes to the host |
| port_in | output | NUM_PORTS*DW | Incoming bytes from the host |
| dsp_addr | output | DSP_AW | DSP register address |
| dsp_we | output | 1 | DSP register write strobe |
| dsp_wdata | output | DW | DSP register write data |
| dsp_rdata | input | DW | DSP register read data (combinational) |

## Verification
Three kinds of result have different timing. RAM and DSP strobes are combinational and are checked in the write cycle itself, before the edge. Register updates (ports, DSP address, control) are due right after the edge that takes the write. Read data is due one edge after `cpu_rd`. The bench drives inputs on the falling edge and samples at the next falling edge, so each check lands exactly on the cycle where its result is due. DSP write pulses are counted at every rising edge, which shows whether a write was dropped.

// File: rtl/snd_regwin_pkg.sv
package snd_regwin_pkg;
   // window offsets; the ordering is what the CPU software decodes
   localparam logic [3:0] OFS_TEST  = 4'h0;
   localparam logic [3:0] OFS_CTRL  = 4'h1;
   localparam logic [3:0] OFS_DADDR = 4'h2;
   localparam logic [3:0] OFS_DDATA = 4'h3;
   localparam logic [3:0] OFS_PORT0 = 4'h4;
   localparam logic [3:0] OFS_SCR0  = 4'h8;

   // control register bit positions
   localparam int CTRL_CLR_LO = 4;
   localparam int CTRL_ROM    = 7;

   typedef enum logic [1:0] {
      SRC_REG = 2'd0,
      SRC_ROM = 2'd1,
      SRC_RAM = 2'd2
   } rd_src_e;
endpackage

// File: rtl/snd_port_bank.sv
module snd_port_bank #(
   parameter int NUM_PORTS = 4,
   parameter int DW        = 8,
   localparam int PSEL_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int PAIRS    = NUM_PORTS / 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [NUM_PORTS-1:0]    cpu_out_we,
   input  logic [DW-1:0]           cpu_wdata,
   input  logic                    host_we,
   input  logic [PSEL_W-1:0]       host_sel,
   input  logic [DW-1:0]           host_wdata,
   input  logic [PAIRS-1:0]        clr_pair,
   output logic [NUM_PORTS*DW-1:0] port_out,
   output logic [NUM_PORTS*DW-1:0] port_in
);
   for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
      logic [DW-1:0] out_q;
      logic [DW-1:0] in_q;
      logic          host_hit;

      assign host_hit = host_we && (host_sel == PSEL_W'(k));

      always_ff @(posedge clk) begin
         if (rst) begin
            out_q <= '0;
         end else if (cpu_out_we[k]) begin
            out_q <= cpu_wdata;
         end
      end

      // clear takes priority over a simultaneous host write
      always_ff @(posedge clk) begin
         if (rst || clr_pair[k/2]) begin
            in_q <= '0;
         end else if (host_hit) begin
            in_q <= host_wdata;
         end
      end

      assign port_out[k*DW +: DW] = out_q;
      assign port_in[k*DW +: DW]  = in_q;
   end
endmodule

// File: rtl/snd_dsp_bridge.sv
module snd_dsp_bridge #(
   parameter int DW     = 8,
   parameter int DSP_AW = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              addr_we,
   input  logic              data_we,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     addr_full,
   output logic [DSP_AW-1:0] dsp_addr,
   output logic              dsp_we,
   output logic [DW-1:0]     dsp_wdata
);
   logic [DW-1:0] addr_q;
   logic          in_range;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
      end else if (addr_we) begin
         addr_q <= wdata;
      end
   end

   assign in_range  = (addr_q >> DSP_AW) == '0;
   assign addr_full = addr_q;
   assign dsp_addr  = addr_q[DSP_AW-1:0];
   assign dsp_we    = data_we && in_range;
   assign dsp_wdata = wdata;
endmodule

// File: rtl/snd_rom_overlay.sv
module snd_rom_overlay #(
   parameter int ADDR_W    = 16,
   parameter int DW        = 8,
   parameter int ROM_BYTES = 64,
   parameter logic [ROM_BYTES*DW-1:0] ROM_IMAGE = {ROM_BYTES{8'hFF}},
   localparam int ROM_AW   = $clog2(ROM_BYTES)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              enable,
   output logic              hit,
   output logic [DW-1:0]     rdata
);
   logic [ROM_AW-1:0] idx;

   assign idx   = addr[ROM_AW-1:0];
   assign hit   = enable && (&addr[ADDR_W-1:ROM_AW]);
   assign rdata = ROM_IMAGE[idx*DW +: DW];
endmodule

// File: rtl/snd_regwin.sv
module snd_regwin
   import snd_regwin_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DW        = 8,
   parameter int NUM_PORTS = 4,
   parameter int DSP_AW    = 7,
   parameter int SCRATCH_N = 2,
   parameter int ROM_BYTES = 64,
   parameter logic [ADDR_W-1:0] WIN_BASE = 16'h00F0,
   parameter logic [ROM_BYTES*DW-1:0] ROM_IMAGE = {ROM_BYTES{8'hFF}},
   parameter int PSEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [ADDR_W-1:0]       cpu_addr,
   input  logic [DW-1:0]           cpu_wdata,
   input  logic                    cpu_wr,
   input  logic                    cpu_rd,
   output logic [DW-1:0]           cpu_rdata,
   output logic                    ram_we,
   output logic [ADDR_W-1:0]       ram_addr,
   output logic [DW-1:0]           ram_wdata,
   input  logic [DW-1:0]           ram_rdata,
   input  logic                    host_we,
   input  logic [PSEL_W-1:0]       host_sel,
   input  logic [DW-1:0]           host_wdata,
   output logic [NUM_PORTS*DW-1:0] port_out,
   output logic [NUM_PORTS*DW-1:0] port_in,
   output logic [DSP_AW-1:0]       dsp_addr,
   output logic                    dsp_we,
   output logic [DW-1:0]           dsp_wdata,
   input  logic [DW-1:0]           dsp_rdata
);
   localparam int PAIRS = NUM_PORTS / 2;

   // elaboration-time parameter checks
   if (DW != 8) begin : g_bad_dw
      $error("snd_regwin: DW must be 8");
   end
   if (NUM_PORTS != 2 && NUM_PORTS != 4) begin : g_bad_ports
      $error("snd_regwin: NUM_PORTS must be 2 or 4");
   end
   if (SCRATCH_N < 1 || SCRATCH_N > 2) begin : g_bad_scr
      $error("snd_regwin: SCRATCH_N must be 1 or 2");
   end
   if (DSP_AW < 1 || DSP_AW >= DW) begin : g_bad_daw
      $error("snd_regwin: DSP_AW out of range");
   end
   if ((ROM_BYTES & (ROM_BYTES - 1)) != 0 || ROM_BYTES < 2) begin : g_bad_rom
      $error("snd_regwin: ROM_BYTES must be a power of two");
   end
   if (WIN_BASE[3:0] != 4'h0) begin : g_bad_base
      $error("snd_regwin: WIN_BASE must be 16-byte aligned");
   end
   if ((longint'(WIN_BASE) + 16) > ((longint'(1) << ADDR_W) - ROM_BYTES)) begin : g_bad_overlap
      $error("snd_regwin: window overlaps ROM range");
   end

   // ---------------- decode ----------------
   logic       win_hit;
   logic [3:0] ofs;
   logic       wr_win;
   logic       ctrl_we;

   assign win_hit = (cpu_addr[ADDR_W-1:4] == WIN_BASE[ADDR_W-1:4]);
   assign ofs     = cpu_addr[3:0];
   assign wr_win  = cpu_wr && win_hit;
   assign ctrl_we = wr_win && (ofs == OFS_CTRL);

   // RAM write-through
   assign ram_we    = cpu_wr;
   assign ram_addr  = cpu_addr;
   assign ram_wdata = cpu_wdata;

   // ---------------- control ----------------
   logic             rom_en_q;
   logic [PAIRS-1:0] clr_pair;

   always_ff @(posedge clk) begin
      if (rst) begin
         rom_en_q <= 1'b1;
      end else if (ctrl_we) begin
         rom_en_q <= cpu_wdata[CTRL_ROM];
      end
   end

   for (genvar p = 0; p < PAIRS; p++) begin : g_clr
      assign clr_pair[p] = ctrl_we && cpu_wdata[CTRL_CLR_LO + p];
   end

   // ---------------- host ports ----------------
   logic [NUM_PORTS-1:0] port_we;

   for (genvar k = 0; k < NUM_PORTS; k++) begin : g_pwe
      assign port_we[k] = wr_win && (ofs == 4'(OFS_PORT0 + k));
   end

   snd_port_bank #(
      .NUM_PORTS (NUM_PORTS),
      .DW        (DW)
   ) u_ports (
      .clk        (clk),
      .rst        (rst),
      .cpu_out_we (port_we),
      .cpu_wdata  (cpu_wdata),
      .host_we    (host_we),
      .host_sel   (host_sel),
      .host_wdata (host_wdata),
      .clr_pair   (clr_pair),
      .port_out   (port_out),
      .port_in    (port_in)
   );

   // ---------------- DSP bridge ----------------
   logic [DW-1:0] daddr_full;

   snd_dsp_bridge #(
      .DW     (DW),
      .DSP_AW (DSP_AW)
   ) u_dsp (
      .clk       (clk),
      .rst       (rst),
      .addr_we   (wr_win && (ofs == OFS_DADDR)),
      .data_we   (wr_win && (ofs == OFS_DDATA)),
      .wdata     (cpu_wdata),
      .addr_full (daddr_full),
      .dsp_addr  (dsp_addr),
      .dsp_we    (dsp_we),
      .dsp_wdata (dsp_wdata)
   );

   // ---------------- scratch bytes ----------------
   logic [DW-1:0] scr_q [SCRATCH_N];

   for (genvar s = 0; s < SCRATCH_N; s++) begin : g_scr
      always_ff @(posedge clk) begin
         if (rst) begin
            scr_q[s] <= '0;
         end else if (wr_win && (ofs == 4'(OFS_SCR0 + s))) begin
            scr_q[s] <= cpu_wdata;
         end
      end
   end

   // ---------------- ROM overlay ----------------
   logic          rom_hit;
   logic [DW-1:0] rom_byte;

   snd_rom_overlay #(
      .ADDR_W    (ADDR_W),
      .DW        (DW),
      .ROM_BYTES (ROM_BYTES),
      .ROM_IMAGE (ROM_IMAGE)
   ) u_rom (
      .addr   (cpu_addr),
      .enable (rom_en_q),
      .hit    (rom_hit),
      .rdata  (rom_byte)
   );

   // ---------------- read path ----------------
   logic [DW-1:0] reg_val;
   rd_src_e       src_d;
   rd_src_e       src_q;
   logic [DW-1:0] hold_q;

   always_comb begin
      reg_val = '0;
      if (ofs == OFS_DADDR) reg_val = daddr_full;
      if (ofs == OFS_DDATA) reg_val = dsp_rdata;
      for (int k = 0; k < NUM_PORTS; k++) begin
         if (ofs == 4'(OFS_PORT0 + k)) reg_val = port_in[k*DW +: DW];
      end
      for (int s = 0; s < SCRATCH_N; s++) begin
         if (ofs == 4'(OFS_SCR0 + s)) reg_val = scr_q[s];
      end
   end

   always_comb begin
      if (win_hit)      src_d = SRC_REG;
      else if (rom_hit) src_d = SRC_ROM;
      else              src_d = SRC_RAM;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         src_q  <= SRC_REG;
         hold_q <= '0;
      end else if (cpu_rd) begin
         src_q  <= src_d;
         hold_q <= (src_d == SRC_ROM) ? rom_byte : reg_val;
      end
   end

   assign cpu_rdata = (src_q == SRC_RAM) ? ram_rdata : hold_q;
endmodule

// File: rtl/snd_regwin_chk.sv
module snd_regwin_chk #(
   parameter int ADDR_W    = 16,
   parameter int DW        = 8,
   parameter int NUM_PORTS = 4,
   parameter int DSP_AW    = 7,
   parameter logic [ADDR_W-1:0] WIN_BASE = 16'h00F0
) (
   input logic                    clk,
   input logic                    rst,
   input logic [ADDR_W-1:0]       cpu_addr,
   input logic [DW-1:0]           cpu_wdata,
   input logic                    cpu_wr,
   input logic                    host_we,
   input logic [NUM_PORTS*DW-1:0] port_out,
   input logic [NUM_PORTS*DW-1:0] port_in,
   input logic [DSP_AW-1:0]       dsp_addr,
   input logic                    dsp_we,
   input logic [DW-1:0]           dsp_wdata
);
   logic wr_ctrl, wr_daddr, wr_port;

   assign wr_ctrl  = cpu_wr && (cpu_addr == WIN_BASE + 1);
   assign wr_daddr = cpu_wr && (cpu_addr == WIN_BASE + 2);
   assign wr_port  = cpu_wr && (cpu_addr >= WIN_BASE + 4) &&
                     (cpu_addr < WIN_BASE + 4 + NUM_PORTS);

   // R4: low pair cleared after a control write with bit 4
   assert_clear_low_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_ctrl && cpu_wdata[4]) |=> (port_in[2*DW-1:0] == '0));

   // R2: outgoing bytes only move on a CPU port write
   assert_out_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !wr_port |=> $stable(port_out));

   // R3: incoming bytes only move on host write or control write
   assert_in_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!host_we && !wr_ctrl) |=> $stable(port_in));

   // R7: DSP strobe only from a data-port write, carrying the CPU byte
   assert_dsp_strobe_R7: assert property (@(posedge clk) disable iff (rst)
      dsp_we |-> (cpu_wr && (cpu_addr == WIN_BASE + 3) && (dsp_wdata == cpu_wdata)));

   // R6: DSP address only moves on an address-latch write
   assert_dsp_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !wr_daddr |=> $stable(dsp_addr));
endmodule

bind snd_regwin snd_regwin_chk #(
   .ADDR_W    (ADDR_W),
   .DW        (DW),
   .NUM_PORTS (NUM_PORTS),
   .DSP_AW    (DSP_AW),
   .WIN_BASE  (WIN_BASE)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cpu_addr  (cpu_addr),
   .cpu_wdata (cpu_wdata),
   .cpu_wr    (cpu_wr),
   .host_we   (host_we),
   .port_out  (port_out),
   .port_in   (port_in),
   .dsp_addr  (dsp_addr),
   .dsp_we    (dsp_we),
   .dsp_wdata (dsp_wdata)
);

// File: tb/snd_regwin_test.sv
`timescale 1ns/1ps
module snd_regwin_test;
   localparam int NP = 4;

   function automatic logic [511:0] make_rom();
      logic [511:0] r;
      for (int i = 0; i < 64; i++) r[i*8 +: 8] = 8'h3C ^ 8'(i);
      return r;
   endfunction
   localparam logic [511:0] ROM_IMG = make_rom();

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_wr = 1'b0;
   logic        cpu_rd = 1'b0;
   logic [7:0]  cpu_rdata;
   logic        ram_we;
   logic [15:0] ram_addr;
   logic [7:0]  ram_wdata;
   logic [7:0]  ram_rdata;
   logic        host_we = 1'b0;
   logic [1:0]  host_sel = '0;
   logic [7:0]  host_wdata = '0;
   logic [31:0] port_out, port_in;
   logic [6:0]  dsp_addr;
   logic        dsp_we;
   logic [7:0]  dsp_wdata;
   logic [7:0]  dsp_rdata;

   int checks = 0;
   int errors = 0;
   int dsp_pulses = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   snd_regwin #(.ROM_IMAGE(ROM_IMG)) uut (
      .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata), .host_we(host_we), .host_sel(host_sel),
      .host_wdata(host_wdata), .port_out(port_out), .port_in(port_in),
      .dsp_addr(dsp_addr), .dsp_we(dsp_we), .dsp_wdata(dsp_wdata),
      .dsp_rdata(dsp_rdata)
   );

   // RAM model: synchronous read, indexed by the low address byte
   logic [7:0] ram_mem [256];
   logic [7:0] ram_q = '0;
   initial for (int i = 0; i < 256; i++) ram_mem[i] = '0;
   always @(posedge clk) begin
      if (ram_we) ram_mem[ram_addr[7:0]] <= ram_wdata;
      ram_q <= ram_mem[ram_addr[7:0]];
   end
   assign ram_rdata = ram_q;

   // DSP register model: combinational read
   logic [7:0] dsp_mem [128];
   initial for (int i = 0; i < 128; i++) dsp_mem[i] = 8'(i) ^ 8'h5A;
   always @(posedge clk) begin
      if (dsp_we) begin
         dsp_mem[dsp_addr] <= dsp_wdata;
         dsp_pulses <= dsp_pulses + 1;
      end
   end
   assign dsp_rdata = dsp_mem[dsp_addr];

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cpu_write(logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic cpu_read(logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_rd = 1'b1;
      @(negedge clk);
      cpu_rd = 1'b0;
      d = cpu_rdata;
   endtask

   task automatic host_write(logic [1:0] k, logic [7:0] d);
      @(negedge clk);
      host_sel = k; host_wdata = d; host_we = 1'b1;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R10 port_out", port_out, 32'h0);
      check("R10 port_in", port_in, 32'h0);
      cpu_read(16'h00F2, d); check("R10 dsp addr", d, 8'h00);
      cpu_read(16'h00F8, d); check("R10 scratch", d, 8'h00);
      cpu_read(16'hFFC0, d); check("R10 rom on", d, 8'h3C);
   endtask

   task automatic t_ram();
      logic [7:0] d;
      @(negedge clk);
      cpu_addr = 16'h0123; cpu_wdata = 8'h5E; cpu_wr = 1'b1;
      #1;
      check("R1 ram_we", {ram_we, ram_addr, ram_wdata}, {1'b1, 16'h0123, 8'h5E});
      @(negedge clk);
      cpu_wr = 1'b0;
      cpu_read(16'h0123, d); check("R1 ram read", d, 8'h5E);
      cpu_write(16'h00F9, 8'h22);
      check("R1 window write reaches RAM", ram_mem[8'hF9], 8'h22);
   endtask

   task automatic t_ports();
      logic [7:0] d;
      cpu_write(16'h00F4, 8'h11);
      cpu_write(16'h00F5, 8'h22);
      cpu_write(16'h00F6, 8'h33);
      cpu_write(16'h00F7, 8'h44);
      check("R2 port_out", port_out, 32'h44332211);
      check("R2 in untouched", port_in, 32'h0);
      host_write(2'd2, 8'hA5);
      check("R3 host write", port_in, 32'h00A50000);
      cpu_read(16'h00F6, d); check("R2 read incoming", d, 8'hA5);
      cpu_read(16'h00F5, d); check("R2 read incoming empty", d, 8'h00);
   endtask

   task automatic t_clear();
      host_write(2'd0, 8'h01);
      host_write(2'd1, 8'h02);
      host_write(2'd3, 8'h04);
      check("R3 all ports", port_in, 32'h04A50201);
      cpu_write(16'h00F1, 8'h90);
      check("R4 clear low pair", port_in, 32'h04A50000);
      cpu_write(16'h00F1, 8'hA0);
      check("R4 clear high pair", port_in, 32'h00000000);
      host_write(2'd1, 8'h77);
      host_write(2'd2, 8'h66);
      // host write and clear in the same cycle: clear wins
      @(negedge clk);
      cpu_addr = 16'h00F1; cpu_wdata = 8'h90; cpu_wr = 1'b1;
      host_sel = 2'd1; host_wdata = 8'h99; host_we = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0; host_we = 1'b0;
      check("R4 clear beats host", port_in, 32'h00660000);
      check("R4 out unaffected", port_out, 32'h44332211);
   endtask

   task automatic t_rom();
      logic [7:0] d;
      cpu_write(16'hFFC5, 8'h77);
      check("R5 write reaches RAM", ram_mem[8'hC5], 8'h77);
      cpu_read(16'hFFC5, d); check("R5 rom read", d, 8'h3C ^ 8'h05);
      cpu_read(16'hFFFF, d); check("R5 rom top", d, 8'h3C ^ 8'h3F);
      cpu_write(16'h00F1, 8'h00);
      cpu_read(16'hFFC5, d); check("R5 rom off reads RAM", d, 8'h77);
      cpu_write(16'h00F1, 8'h80);
      cpu_read(16'hFFC5, d); check("R5 rom back on", d, 8'h39);
   endtask

   task automatic t_dsp();
      logic [7:0] d;
      int p0;
      cpu_write(16'h00F2, 8'h12);
      check("R6 dsp_addr", dsp_addr, 7'h12);
      cpu_read(16'h00F2, d); check("R6 addr readback", d, 8'h12);
      cpu_read(16'h00F3, d); check("R7 dsp read", d, 8'h12 ^ 8'h5A);
      p0 = dsp_pulses;
      cpu_write(16'h00F3, 8'h9A);
      check("R7 one pulse", dsp_pulses - p0, 1);
      cpu_read(16'h00F3, d); check("R7 dsp write", d, 8'h9A);
      cpu_write(16'h00F2, 8'h85);
      check("R6 masked addr", dsp_addr, 7'h05);
      cpu_read(16'h00F2, d); check("R6 full addr readback", d, 8'h85);
      cpu_read(16'h00F3, d); check("R7 masked read", d, 8'h05 ^ 8'h5A);
      p0 = dsp_pulses;
      cpu_write(16'h00F3, 8'hEE);
      check("R7 high addr dropped", dsp_pulses - p0, 0);
      cpu_read(16'h00F3, d); check("R7 reg unchanged", d, 8'h05 ^ 8'h5A);
      cpu_write(16'h00F2, 8'h7F);
      p0 = dsp_pulses;
      cpu_write(16'h00F3, 8'h3E);
      check("R7 boundary 7F accepted", dsp_pulses - p0, 1);
   endtask

   task automatic t_scratch();
      logic [7:0] d;
      cpu_write(16'h00F8, 8'h11);
      cpu_read(16'h00F8, d); check("R8 scratch0", d, 8'h11);
      cpu_read(16'h00F9, d); check("R8 scratch1", d, 8'h22);
   endtask

   task automatic t_test_reg();
      logic [7:0] d;
      logic [31:0] po, pi;
      po = port_out; pi = port_in;
      cpu_write(16'h00F0, 8'hFF);
      check("R9 port_out kept", port_out, po);
      check("R9 port_in kept", port_in, pi);
      check("R9 dsp addr kept", dsp_addr, 7'h7F);
      cpu_read(16'hFFC1, d); check("R9 rom kept", d, 8'h3D);
      cpu_read(16'h00F0, d); check("R9 read test", d, 8'h00);
      cpu_read(16'h00F1, d); check("R9 read ctrl", d, 8'h00);
      cpu_read(16'h00FA, d); check("R9 read FA", d, 8'h00);
      cpu_read(16'h00FF, d); check("R9 read FF", d, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_ram();
      t_ports();
      t_clear();
      t_rom();
      t_dsp();
      t_scratch();
      t_test_reg();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule